// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

The block sits beside a processor core and decides, once per armed evaluation, whether pending interrupt requests justify a trap. It has two sources of requests. The first is a software request register that is written through a simple write port. The second is a live external request vector. Both sources feed one shared level space. A software bit in the range 4 to 18 maps to level `bit - 3`, so it covers levels 1 to 15. An external bit in the range 20 to 30 maps to the level equal to its bit number. Within each source the highest set bit wins. Any pending external request overrides the level chosen from the software source.

The core owns a 5-bit current priority level register. A trap fires only when the resolved level is nonzero and strictly above that register. When a trap fires, two status registers are loaded in the same edge: one holds the summary word of every pending bit, the other holds the resolved level. The trap itself appears as a one-cycle pulse.

Every evaluation consumes the arm flag. A return-from-exception strobe, accepted only while the core is in privileged mode, sets the flag again. Reset clears the flag, so no evaluation takes place until the first accepted strobe.

Top module: `irq_level_resolver`

## Requirements
- R1: After reset, `trap_o`, `summary_o`, `level_o`, `sw_req_o` and `ipl_o` are zero, and the arm flag is clear: no trap occurs whatever the requests, until a strobe is accepted.
- R2: A write to the software request register keeps only bits 4 through 18 (mask 0x0007FFF0); all other written bits read back as zero on `sw_req_o`.
- R3: The software level is `i - 3`, where `i` is the highest set bit of the software register in bits 4 to 18; it is 0 when none of those bits is set.
- R4: The external level is `i`, where `i` is the highest set bit of `ext_req` in bits 20 to 30. When any such bit is set, it replaces the software level. External bits outside 20 to 30 are ignored.
- R5: The summary word is the OR of the masked software bits and the in-range external bits, each in its own position (in-range external mask 0x7FF00000).
- R6: An armed evaluation raises a trap only if the resolved level is nonzero and strictly greater than `ipl_o`. Otherwise there is no pulse, and `summary_o` and `level_o` keep their values.
- R7: `trap_o` is high for exactly one cycle. It rises in the cycle after the edge that samples the arm flag high. `summary_o` and `level_o` take their new values at that same edge.
- R8: Each evaluation clears the arm flag. `rei_i` sets it only when `priv_i` is high. A strobe with `priv_i` low has no effect.
- R9: If an accepted strobe arrives in the same cycle as an evaluation, the flag stays set, and the next cycle evaluates again.
- R10: The priority level register stores `ipl_wr_data` on `ipl_wr_en`. The comparison uses the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Write strobe for the software request register |
| sw_wr_data | input | 32 | Data for the software request register |
| ipl_wr_en | input | 1 | Write strobe for the priority level register |
| ipl_wr_data | input | 5 | Data for the priority level register |
| ext_req | input | 32 | External request status vector |
| rei_i | input | 1 | Return-from-exception strobe |
| priv_i | input | 1 | Core is in privileged mode |
| trap_o | output | 1 | One-cycle interrupt trap request |
| summary_o | output | 32 | Summary status register |
| level_o | output | 5 | Interrupt level status register |
| sw_req_o | output | 32 | Software request register contents |
| ipl_o | output | 5 | Current priority level register |

## Verification
A wrong arm flag is visible at the ports as a missing trap, or as a trap with no strobe before it. This shows up within two cycles of the strobe. A wrong priority choice or a wrong level offset shows up in `level_o` in the cycle of the trap pulse. It also moves the boundary where the trap stops firing as `ipl_o` is swept past the resolved level. A wrong mask shows up as a wrong `sw_req_o` one cycle after the write, or as stray bits in `summary_o` at the next trap.

// File: rtl/ilr_pkg.sv
package ilr_pkg;
  localparam int VEC_W = 32;
  localparam int LVL_W = 5;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [LVL_W-1:0] lvl_t;

  // mask with bits lo..hi-1 set
  function automatic vec_t span_mask(input int lo, input int hi);
    vec_t m;
    m = '0;
    for (int i = 0; i < VEC_W; i++)
      if (i >= lo && i < hi) m[i] = 1'b1;
    return m;
  endfunction

  // level of highest set bit in lo..hi-1, as (bit - base); 0 when none
  function automatic lvl_t top_level(input vec_t v, input int lo, input int hi, input int base);
    lvl_t l;
    l = '0;
    for (int i = 0; i < VEC_W; i++)
      if (i >= lo && i < hi && v[i]) l = lvl_t'(i - base);
    return l;
  endfunction
endpackage

// File: rtl/ilr_csr.sv
module ilr_csr
  import ilr_pkg::*;
#(
  parameter int SW_LO = 4,
  parameter int SW_HI = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr_en,
  input  vec_t sw_wr_data,
  input  logic ipl_wr_en,
  input  lvl_t ipl_wr_data,
  output vec_t sw_q,
  output lvl_t ipl_q
);
  localparam vec_t SW_MASK = span_mask(SW_LO, SW_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q  <= '0;
      ipl_q <= '0;
    end else begin
      if (sw_wr_en)  sw_q  <= sw_wr_data & SW_MASK;
      if (ipl_wr_en) ipl_q <= ipl_wr_data;
    end
  end

  p_sw_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q & ~SW_MASK) == '0);
endmodule

// File: rtl/ilr_encode.sv
module ilr_encode
  import ilr_pkg::*;
#(
  parameter int LO   = 4,
  parameter int HI   = 19,
  parameter int BASE = 3
) (
  input  vec_t req,
  output vec_t pend,
  output lvl_t level,
  output logic any
);
  vec_t mask;
  for (genvar g = 0; g < VEC_W; g++) begin : g_mask
    if (g >= LO && g < HI) begin : g_in
      assign mask[g] = 1'b1;
    end else begin : g_out
      assign mask[g] = 1'b0;
    end
  end

  assign pend  = req & mask;
  assign level = top_level(pend, LO, HI, BASE);
  assign any   = |pend;

  always_comb begin
    a_level_any_r3: assert ((level != '0) == any);
  end
endmodule

// File: rtl/ilr_arm.sv
module ilr_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic rei_i,
  input  logic priv_i,
  output logic armed,
  output logic rearm
);
  assign rearm = rei_i & priv_i;

  always_ff @(posedge clk) begin
    if (!rst_n)     armed <= 1'b0;
    else if (rearm) armed <= 1'b1;
    else if (armed) armed <= 1'b0;
  end

  p_eval_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !rearm |=> !armed);
  p_rearm_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> armed);
  p_unpriv_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !rearm |=> !armed);
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import ilr_pkg::*;
#(
  parameter int SW_LO  = 4,
  parameter int SW_HI  = 19,
  parameter int EXT_LO = 20,
  parameter int EXT_HI = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr_en,
  input  logic [VEC_W-1:0]  sw_wr_data,
  input  logic              ipl_wr_en,
  input  logic [LVL_W-1:0]  ipl_wr_data,
  input  logic [VEC_W-1:0]  ext_req,
  input  logic              rei_i,
  input  logic              priv_i,
  output logic              trap_o,
  output logic [VEC_W-1:0]  summary_o,
  output logic [LVL_W-1:0]  level_o,
  output logic [VEC_W-1:0]  sw_req_o,
  output logic [LVL_W-1:0]  ipl_o
);
  localparam int SW_BASE = SW_LO - 1;

  vec_t sw_q, sw_pend, ext_pend, sum_now;
  lvl_t ipl_q, sw_lvl, ext_lvl, lvl_now;
  logic sw_any, ext_any, armed, rearm;
  logic eval_fire, take_trap;
  logic trap_q;
  vec_t summary_q;
  lvl_t level_q;

  ilr_csr #(.SW_LO(SW_LO), .SW_HI(SW_HI)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .ipl_wr_en(ipl_wr_en), .ipl_wr_data(ipl_wr_data),
    .sw_q(sw_q), .ipl_q(ipl_q)
  );

  ilr_encode #(.LO(SW_LO), .HI(SW_HI), .BASE(SW_BASE)) u_sw_enc (
    .req(sw_q), .pend(sw_pend), .level(sw_lvl), .any(sw_any)
  );

  ilr_encode #(.LO(EXT_LO), .HI(EXT_HI), .BASE(0)) u_ext_enc (
    .req(ext_req), .pend(ext_pend), .level(ext_lvl), .any(ext_any)
  );

  ilr_arm u_arm (
    .clk(clk), .rst_n(rst_n), .rei_i(rei_i), .priv_i(priv_i),
    .armed(armed), .rearm(rearm)
  );

  // external requests override the software choice
  assign lvl_now   = ext_any ? ext_lvl : sw_lvl;
  assign sum_now   = sw_pend | ext_pend;
  assign eval_fire = armed;
  assign take_trap = eval_fire && (lvl_now != '0) && (lvl_now > ipl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_q    <= 1'b0;
      summary_q <= '0;
      level_q   <= '0;
    end else begin
      trap_q <= take_trap;
      if (take_trap) begin
        summary_q <= sum_now;
        level_q   <= lvl_now;
      end
    end
  end

  assign trap_o    = trap_q;
  assign summary_o = summary_q;
  assign level_o   = level_q;
  assign sw_req_o  = sw_q;
  assign ipl_o     = ipl_q;

  p_trap_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(armed));
  p_level_above_ipl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (level_o != '0) && (level_o > $past(ipl_q)));
  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |-> $stable(level_o) && $stable(summary_o));
  p_level_in_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o && (level_o >= lvl_t'(EXT_LO)) |-> summary_o[level_o]);
  p_ext_override_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eval_fire && ext_any |=> !trap_o || (level_o >= lvl_t'(EXT_LO)));
endmodule

// File: tb/sim_irq_level_resolver.sv
module sim_irq_level_resolver;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_wr_en = 1'b0;
  logic [31:0] sw_wr_data = '0;
  logic ipl_wr_en = 1'b0;
  logic [4:0] ipl_wr_data = '0;
  logic [31:0] ext_req = '0;
  logic rei_i = 1'b0;
  logic priv_i = 1'b0;
  logic trap_o;
  logic [31:0] summary_o, sw_req_o;
  logic [4:0] level_o, ipl_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_sum = '0;
  logic [4:0]  exp_lvl = '0;
  logic [31:0] rng = 32'h1234_5677;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_resolver u0 (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .ipl_wr_en(ipl_wr_en), .ipl_wr_data(ipl_wr_data), .ext_req(ext_req),
    .rei_i(rei_i), .priv_i(priv_i), .trap_o(trap_o), .summary_o(summary_o),
    .level_o(level_o), .sw_req_o(sw_req_o), .ipl_o(ipl_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // software level: highest bit among 4..18, offset down by 3
  function automatic logic [4:0] model_sw(input logic [31:0] v);
    for (int i = 18; i >= 4; i--) if (v[i]) return 5'(i - 3);
    return 5'd0;
  endfunction

  function automatic logic [4:0] model_ext(input logic [31:0] v);
    for (int i = 30; i >= 20; i--) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic do_eval(input logic [31:0] sw, input logic [31:0] ext, input logic [4:0] ipl);
    logic [31:0] swm, sm;
    logic [4:0]  lv;
    logic        tk;
    @(negedge clk);
    sw_wr_en = 1; sw_wr_data = sw; ipl_wr_en = 1; ipl_wr_data = ipl; ext_req = ext;
    @(negedge clk);
    sw_wr_en = 0; ipl_wr_en = 0;
    swm = sw & 32'h0007_FFF0;
    chk("R2 sw mask", sw_req_o, swm);
    chk("R10 ipl store", {27'd0, ipl_o}, {27'd0, ipl});
    rei_i = 1; priv_i = 1;
    @(negedge clk);
    rei_i = 0; priv_i = 0;
    @(negedge clk);
    lv = (ext & 32'h7FF0_0000) != 0 ? model_ext(ext) : model_sw(swm);
    sm = swm | (ext & 32'h7FF0_0000);
    tk = (lv != 0) && (lv > ipl);
    if (tk) begin exp_sum = sm; exp_lvl = lv; end
    chk("R6 trap decision", {31'd0, trap_o}, {31'd0, tk});
    chk("R3/R4 level", {27'd0, level_o}, {27'd0, exp_lvl});
    chk("R5 summary", summary_o, exp_sum);
    @(negedge clk);
    chk("R7 single pulse", {31'd0, trap_o}, 32'd0);
    @(negedge clk);
    chk("R8 disarmed after eval", {31'd0, trap_o}, 32'd0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 10000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state and no trap while disarmed
    chk("R1 reset trap", {31'd0, trap_o}, 32'd0);
    chk("R1 reset summary", summary_o, 32'd0);
    chk("R1 reset level", {27'd0, level_o}, 32'd0);
    chk("R1 reset sw", sw_req_o, 32'd0);
    chk("R1 reset ipl", {27'd0, ipl_o}, 32'd0);
    ext_req = 32'h4000_0000;
    repeat (4) begin
      @(negedge clk);
      chk("R1 disarmed after reset", {31'd0, trap_o}, 32'd0);
    end
    ext_req = '0;

    // R2/R3: each software bit alone
    for (int b = 0; b < 32; b++) do_eval(32'd1 << b, 32'd0, 5'd0);
    // R4: each external bit alone, over a software request
    for (int b = 0; b < 32; b++) do_eval(32'h0004_0000, 32'd1 << b, 5'd0);
    // R6: sweep priority level around fixed levels
    for (int p = 0; p < 32; p++) do_eval(32'h0000_0400, 32'd0, 5'(p));
    for (int p = 0; p < 32; p++) do_eval(32'h0000_0000, 32'h0020_0000, 5'(p));
    // mixed patterns
    for (int k = 0; k < 120; k++) begin
      logic [31:0] a, c;
      rng = next_rng(rng); a = rng;
      rng = next_rng(rng); c = (k % 3 == 0) ? 32'd0 : rng;
      rng = next_rng(rng);
      do_eval(a, c, rng[4:0]);
    end

    // R8: strobe outside privileged mode is ignored
    do_eval(32'h0004_0000, 32'd0, 5'd0);
    @(negedge clk); rei_i = 1; priv_i = 0;
    @(negedge clk); rei_i = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R8 unprivileged strobe ignored", {31'd0, trap_o}, 32'd0);
    end

    // R9: strobe held two cycles -> arm, then evaluate and rearm -> two traps
    @(negedge clk); ext_req = 32'h0100_0000; rei_i = 1; priv_i = 1;
    @(negedge clk);
    @(negedge clk); rei_i = 0; priv_i = 0;
    chk("R9 first trap", {31'd0, trap_o}, 32'd1);
    chk("R9 level", {27'd0, level_o}, 32'd24);
    @(negedge clk);
    chk("R9 second trap after rearm", {31'd0, trap_o}, 32'd1);
    @(negedge clk);
    chk("R9 then disarmed", {31'd0, trap_o}, 32'd0);
    chk("R5 summary with sw", summary_o, 32'h0104_0000);
    ext_req = '0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule